// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a host processor read and write a small bank of 8-bit configuration registers over a four-signal serial link. The signals are an active-low select, a serial clock, a shared data line and an optional dedicated return line. A transfer starts when select goes low. It consists of one instruction byte and then exactly one data byte. The instruction byte carries a direction flag, a two-bit length field and a five-bit register address. Select going high ends or abandons the transfer at any point.

Register 0 is the control register. Bit 7 of register 0 chooses the bit order, for both the instruction byte and the data byte. Bit 6 of register 0 chooses where read data returns: on the shared line (3-wire) or on the dedicated return line (4-wire). The block is clocked by a fast system clock. It samples select, serial clock and data through a synchronizer and acts on detected serial-clock edges. Each physical pin driver is modelled as a data output plus an enable.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, every register holds 0x00, so transfers are MSB-first and in 3-wire mode, and both output enables are low.
- R2: The instruction byte is sampled on rising serial-clock edges after select falls. In MSB-first order the bits are: the direction bit (1 = read, 0 = write), then the two length bits (high bit first), then the five address bits (A4 first).
- R3: For a write, the next eight rising edges sample the data byte. It is stored in the addressed register only after the eighth data bit. Writes to addresses at or above the register count are dropped.
- R4: For a read, the addressed register is driven out one bit per falling serial-clock edge. The first bit comes on the falling edge that follows the last instruction bit. Addresses at or above the register count read as 0x00.
- R5: When bit 6 of register 0 is 0 (3-wire mode), read data appears on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low.
- R6: When bit 6 of register 0 is 1 (4-wire mode), read data appears on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low for the whole transfer.
- R7: Both output enables are low during the instruction byte, throughout writes, and whenever select is high.
- R8: When bit 7 of register 0 is 1 (LSB-first), both bytes travel least-significant bit first. The instruction byte then arrives as A0..A4, then the low length bit, then the high length bit, then the direction bit.
- R9: Select going high mid-transfer discards a partial write. The next transfer restarts at its first instruction bit.
- R10: A change to bit 6 or bit 7 of register 0 takes effect from the next transfer after select has gone high, never within the current one.
- R11: The length field has no effect: every transfer moves exactly one data byte, whatever its length bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Value seen on the shared data line |
| sdio_o | output | 1 | Drive value for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Drive value for the dedicated return line |
| sdo_oe | output | 1 | Drive enable for the dedicated return line |
| regs_o | output | NREG*8 | Flattened register contents, register 0 in the low byte |

## Verification
The embedded properties watch, on every cycle, four things. First, select high clears the bit counter and the read phase. Second, the latched order and wiring choices stay frozen while select is low. Third, read drive happens only after a read header. Fourth, a store fires only on the final data edge. Several behaviours can only be shown by the bench's serial scenarios: correct bit order in both directions, the pin chosen for returned data, that out-of-range addresses and the length field change nothing, and that an abandoned write leaves its register untouched.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    // Decoded instruction byte; the layout is the same in both bit orders
    // because the shifter places the first received bit accordingly.
    typedef struct packed {
        logic       rd;
        logic [1:0] len;
        logic [4:0] addr;
    } hdr_t;

    localparam int unsigned BITS_PER_BYTE = 8;
    localparam int unsigned FRAME_BITS    = 2 * BITS_PER_BYTE;
    localparam int unsigned CNT_W         = $clog2(FRAME_BITS + 1);

    localparam int unsigned CTRL_ORDER_BIT = 7;
    localparam int unsigned CTRL_WIRE_BIT  = 6;

    // Shift one received bit into a byte assembler.
    function automatic logic [7:0] shift_in(input logic [7:0] cur,
                                            input logic       b,
                                            input logic       lsb_first);
        return lsb_first ? {b, cur[7:1]} : {cur[6:0], b};
    endfunction

    // Index of the data bit to send at output slot j.
    function automatic logic [2:0] out_idx(input logic       lsb_first,
                                           input logic [2:0] j);
        return lsb_first ? j : ~j;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdio_i,
    output logic cs_q,
    output logic rise,
    output logic fall,
    output logic din
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] cs_p, ck_p, d_p;
    logic         ck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p    <= '1;
            ck_p    <= '0;
            d_p     <= '0;
            ck_last <= 1'b0;
        end else begin
            cs_p    <= {cs_p[TOP-1:0], cs_n};
            ck_p    <= {ck_p[TOP-1:0], sclk};
            d_p     <= {d_p[TOP-1:0], sdio_i};
            ck_last <= ck_p[TOP];
        end
    end

    assign cs_q = cs_p[TOP];
    assign din  = d_p[TOP];
    assign rise = ck_p[TOP] & ~ck_last;
    assign fall = ~ck_p[TOP] & ck_last;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_q,
    input  logic       rise,
    input  logic       fall,
    input  logic       din,
    input  logic       cfg_lsb,
    input  logic       cfg_4w,
    input  logic [7:0] rd_byte,
    output logic [4:0] acc_addr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sdio_o,
    output logic       sdio_oe,
    output logic       sdo_o,
    output logic       sdo_oe
);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(BITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] DATA_FST  = CNT_W'(BITS_PER_BYTE);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] DONE      = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       sh, sh_next;
    hdr_t             hdr;
    logic             xfer_lsb, xfer_4w;
    logic             rd_active, out_bit;
    logic             in_data;

    assign sh_next = shift_in(sh, din, xfer_lsb);
    assign in_data = (cnt >= DATA_FST) && (cnt <= LAST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            sh        <= '0;
            hdr       <= '0;
            xfer_lsb  <= 1'b0;
            xfer_4w   <= 1'b0;
            rd_active <= 1'b0;
            out_bit   <= 1'b0;
        end else if (cs_q) begin
            cnt       <= '0;
            sh        <= '0;
            rd_active <= 1'b0;
            out_bit   <= 1'b0;
            xfer_lsb  <= cfg_lsb;
            xfer_4w   <= cfg_4w;
        end else begin
            if (rise && cnt != DONE) begin
                cnt <= cnt + 1'b1;
                sh  <= sh_next;
                if (cnt == LAST_HDR)
                    hdr <= hdr_t'(sh_next);
            end
            if (fall && hdr.rd && in_data) begin
                rd_active <= 1'b1;
                out_bit   <= rd_byte[out_idx(xfer_lsb, cnt[2:0])];
            end
        end
    end

    assign acc_addr = hdr.addr;
    assign wr_en    = rise && !cs_q && (cnt == LAST_DATA) && !hdr.rd;
    assign wr_data  = sh_next;

    assign sdio_oe = rd_active & ~xfer_4w;
    assign sdo_oe  = rd_active &  xfer_4w;
    assign sdio_o  = sdio_oe & out_bit;
    assign sdo_o   = sdo_oe  & out_bit;

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q |=> (cnt == '0) && !rd_active);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_q && $past(!cs_q)) |-> ($stable(xfer_lsb) && $stable(xfer_4w)));

    // R7
    read_phase_chk: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> (hdr.rd && cnt >= DATA_FST));

    // R3
    write_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == DONE));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int unsigned NREG = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      addr,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_byte,
    output logic            cfg_lsb,
    output logic            cfg_4w,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && addr == 5'(g))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREG; i++)
            if (addr == 5'(i))
                rd_byte = regs[i];
    end

    assign cfg_lsb = regs[0][CTRL_ORDER_BIT];
    assign cfg_4w  = regs[0][CTRL_WIRE_BIT];

    // R3
    bank_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 5'd1) |=> (regs[1] == $past(wr_data)));

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
    parameter int unsigned NREG        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [NREG*8-1:0] regs_o
);
    logic       cs_q, rise, fall, din;
    logic       cfg_lsb, cfg_4w, wr_en;
    logic [4:0] acc_addr;
    logic [7:0] wr_data, rd_byte;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
        .cs_q(cs_q), .rise(rise), .fall(fall), .din(din)
    );

    spi_frame_ctrl u_frame (
        .clk(clk), .rst(rst), .cs_q(cs_q), .rise(rise), .fall(fall),
        .din(din), .cfg_lsb(cfg_lsb), .cfg_4w(cfg_4w), .rd_byte(rd_byte),
        .acc_addr(acc_addr), .wr_en(wr_en), .wr_data(wr_data),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    spi_reg_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst(rst), .addr(acc_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_byte(rd_byte), .cfg_lsb(cfg_lsb),
        .cfg_4w(cfg_4w), .regs_flat(regs_o)
    );

    // R5
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [NREG*8-1:0] regs_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_reg_port #(.NREG(NREG)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .regs_o(regs_o)
    );

    // entry = {rd, len[1:0], addr[4:0], data_or_expected[7:0]}
    localparam logic [15:0] TBL [11] = '{
        {1'b0, 2'd0, 5'd1, 8'h5A},
        {1'b0, 2'd0, 5'd2, 8'hC3},
        {1'b0, 2'd0, 5'd7, 8'h81},
        {1'b1, 2'd0, 5'd1, 8'h5A},
        {1'b1, 2'd0, 5'd2, 8'hC3},
        {1'b1, 2'd0, 5'd7, 8'h81},
        {1'b0, 2'd0, 5'd9, 8'hFF},
        {1'b1, 2'd0, 5'd9, 8'h00},
        {1'b1, 2'd0, 5'd3, 8'h00},
        {1'b0, 2'd3, 5'd3, 8'h3C},
        {1'b1, 2'd2, 5'd3, 8'h3C}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One serial transfer of nbits bits; gathers read data and drive statistics.
    task automatic xfer(input logic [7:0] h, input logic [7:0] d, input bit lsb,
                        input int nbits, output logic [7:0] rd,
                        output int n3, output int n4, output int nstray);
        rd = '0; n3 = 0; n4 = 0; nstray = 0;
        sclk = 1'b0;
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8) sdio_i = lsb ? h[i] : h[7-i];
            else       sdio_i = lsb ? d[i-8] : d[15-i];
            sclk = 1'b0;
            repeat (8) @(negedge clk);
            if (i < 8) begin
                if (sdio_oe || sdo_oe) nstray++;
            end else begin
                if (sdio_oe) n3++;
                if (sdo_oe)  n4++;
                if (lsb) rd[i-8]  = sdio_oe ? sdio_o : sdo_o;
                else     rd[15-i] = sdio_oe ? sdio_o : sdo_o;
            end
            sclk = 1'b1;
            repeat (8) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        if (sdio_oe || sdo_oe) nstray++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        int n3, n4, ns;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state at the ports
        chk(regs_o == '0, "R1 regs", int'(regs_o[31:0]), 0);
        chk(!sdio_oe && !sdo_oe, "R1 enables", int'({sdio_oe, sdo_oe}), 0);

        // R2 R3 R4 R5 R7 R11: table walk, MSB-first, 3-wire
        foreach (TBL[k]) begin
            xfer(TBL[k][15:8], TBL[k][7:0], 1'b0, 16, rd, n3, n4, ns);
            chk(ns == 0, "R7 stray drive", ns, 0);
            if (TBL[k][15]) begin
                chk(rd == TBL[k][7:0], "R4 R2 R11 read data", rd, TBL[k][7:0]);
                chk(n3 == 8 && n4 == 0, "R5 3-wire pin", n3 * 16 + n4, 8 * 16);
            end else begin
                chk(n3 == 0 && n4 == 0, "R7 write drive", n3 * 16 + n4, 0);
            end
        end
        chk(regs_o[8*2 +: 8] == 8'hC3, "R3 stored", regs_o[8*2 +: 8], 8'hC3);

        // R6: 4-wire mode
        xfer({1'b0, 2'd0, 5'd0}, 8'h40, 1'b0, 16, rd, n3, n4, ns);
        xfer({1'b1, 2'd0, 5'd1}, 8'h00, 1'b0, 16, rd, n3, n4, ns);
        chk(rd == 8'h5A, "R6 read data", rd, 8'h5A);
        chk(n3 == 0 && n4 == 8, "R6 return pin", n3 * 16 + n4, 8);
        xfer({1'b0, 2'd0, 5'd0}, 8'h00, 1'b0, 16, rd, n3, n4, ns);

        // R8 R10: switch to LSB-first; the next transfer uses the new order
        xfer({1'b0, 2'd0, 5'd0}, 8'h80, 1'b0, 16, rd, n3, n4, ns);
        chk(regs_o[7:0] == 8'h80, "R10 ctrl", regs_o[7:0], 8'h80);
        xfer({1'b1, 2'd0, 5'd2}, 8'h00, 1'b1, 16, rd, n3, n4, ns);
        chk(rd == 8'hC3, "R8 R10 LSB read", rd, 8'hC3);
        xfer({1'b0, 2'd1, 5'd4}, 8'h96, 1'b1, 16, rd, n3, n4, ns);
        chk(regs_o[8*4 +: 8] == 8'h96, "R8 LSB write", regs_o[8*4 +: 8], 8'h96);
        xfer({1'b1, 2'd0, 5'd4}, 8'h00, 1'b1, 16, rd, n3, n4, ns);
        chk(rd == 8'h96, "R8 LSB readback", rd, 8'h96);

        // R6 R8: LSB-first together with 4-wire
        xfer({1'b0, 2'd0, 5'd0}, 8'hC0, 1'b1, 16, rd, n3, n4, ns);
        xfer({1'b1, 2'd0, 5'd7}, 8'h00, 1'b1, 16, rd, n3, n4, ns);
        chk(rd == 8'h81 && n4 == 8 && n3 == 0, "R6 R8 LSB 4-wire", rd, 8'h81);
        xfer({1'b0, 2'd0, 5'd0}, 8'h00, 1'b1, 16, rd, n3, n4, ns);
        xfer({1'b1, 2'd0, 5'd7}, 8'h00, 1'b0, 16, rd, n3, n4, ns);
        chk(rd == 8'h81 && n3 == 8, "R10 back to MSB 3-wire", rd, 8'h81);

        // R9: abandoned write leaves the register alone, next transfer is clean
        xfer({1'b0, 2'd0, 5'd5}, 8'hA5, 1'b0, 12, rd, n3, n4, ns);
        chk(regs_o[8*5 +: 8] == 8'h00, "R9 partial write", regs_o[8*5 +: 8], 0);
        xfer({1'b1, 2'd0, 5'd1}, 8'h00, 1'b0, 3, rd, n3, n4, ns);
        chk(!sdio_oe && !sdo_oe, "R9 R7 idle after abort", int'({sdio_oe, sdo_oe}), 0);
        xfer({1'b0, 2'd0, 5'd5}, 8'h6E, 1'b0, 16, rd, n3, n4, ns);
        xfer({1'b1, 2'd0, 5'd5}, 8'h00, 1'b0, 16, rd, n3, n4, ns);
        chk(rd == 8'h6E, "R9 restart", rd, 8'h6E);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule